// File: doc/BRIEF.md
# Windowed Signed Sample Averager

The block accumulates a stream of signed samples into windows and, for each finished window, reports the exact sum together with an average. A single strobe input delimits the windows: the sample that arrives with the strobe is the first sample of a new window. On the same clock edge, the sum gathered since the previous strobe is published. Windows therefore follow one another with no idle cycle between them.

The average is the published sum shifted right arithmetically by a run-time amount. This divides by a power of two and rounds toward minus infinity. The shift amount is sampled on the publishing edge. The sum register is wide enough that a window of the largest selectable length, filled with full-scale samples of either sign, is held exactly. Both outputs keep their values until the next strobe. A synchronous active-low reset clears the outputs and the running accumulator.

Top module: `window_averager`

## Requirements
- R1: In a cycle with `rst_n` low at the clock edge, `total_o`, `mean_o` and the running accumulator all become zero. A strobe on the first edge after reset therefore publishes a sum of 0.
- R2: On an edge with `strobe_i` high, `total_o` takes the sum of all samples accepted since the previous strobe edge (or since reset). That sum includes the sample taken at the previous strobe and excludes the current sample.
- R3: The sample on `smp_i` at a strobe edge becomes the first sample of the next window: the accumulator reloads with that sample, sign-extended.
- R4: On an edge with `strobe_i` low, `total_o` and `mean_o` keep their values, whatever `smp_i` and `shift_sel_i` do.
- R5: On a strobe edge, `mean_o` takes the low SMP_W bits of the new sum shifted right arithmetically by the value of `shift_sel_i` on that edge.
- R6: The shift rounds toward minus infinity. For example, a one-sample window of -3 published with `shift_sel_i` = 1 gives `mean_o` = -2.
- R7: `total_o` is SMP_W + 2^SEL_W bits wide and sign-extends every sample. Windows of 2^15 samples at -128, and of 1024 samples at +127 or -128 (SMP_W = 8, SEL_W = 4), produce exact sums.
- R8: Strobes on consecutive edges give windows of one sample each. Every sample belongs to exactly one window.
- R9: With `shift_sel_i` = 0, `mean_o` equals the low SMP_W bits of `total_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| smp_i | input | SMP_W | Signed input sample |
| shift_sel_i | input | SEL_W | Log2 of the window length; used as the right-shift amount for the average |
| strobe_i | input | 1 | Window boundary; the sample present with it opens the next window |
| total_o | output | SMP_W + 2^SEL_W | Signed sum of the last completed window |
| mean_o | output | SMP_W | Signed average of the last completed window (floor) |

## Verification
The hardest case to reach from the ports is a sum near the edge of the wide register. Reaching it takes a window of 2^15 full-scale negative samples, so the bench runs one unbroken stretch of 32768 cycles with no strobe. Rounding toward minus infinity shows only when a negative sum has discarded low bits. The bench builds short windows with odd negative sums and publishes them with non-zero shifts. Hold behaviour is driven by changing the sample and shift inputs freely between strobes, while a behavioural model is compared against the outputs on every cycle.

// File: rtl/wavg_pkg.sv
package wavg_pkg;

    // default geometry of the averager
    localparam int unsigned DEF_SMP_W = 8;
    localparam int unsigned DEF_SEL_W = 4;

    // accumulator action chosen each cycle
    typedef enum logic {
        ACC_ADD  = 1'b0,
        ACC_LOAD = 1'b1
    } acc_op_e;

    // per-cycle control decoded from the strobe
    typedef struct packed {
        acc_op_e op;
        logic    publish;
    } win_ctl_t;

    // width of the full-precision sum for a given geometry
    function automatic int unsigned sum_width(input int unsigned smp_w,
                                              input int unsigned sel_w);
        return smp_w + (32'd1 << sel_w);
    endfunction

    // decode the window strobe into accumulator and publish controls
    function automatic win_ctl_t decode_strobe(input logic strobe);
        win_ctl_t c;
        c.op      = strobe ? ACC_LOAD : ACC_ADD;
        c.publish = strobe;
        return c;
    endfunction

endpackage

// File: rtl/wavg_accum.sv
module wavg_accum
    import wavg_pkg::*;
#(
    parameter int unsigned SMP_W = DEF_SMP_W,
    parameter int unsigned TOT_W = sum_width(DEF_SMP_W, DEF_SEL_W)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  acc_op_e                 op,
    input  logic signed [SMP_W-1:0] smp,
    output logic signed [TOT_W-1:0] acc_q
);

    logic signed [TOT_W-1:0] smp_ext;
    logic signed [TOT_W-1:0] acc_d;

    assign smp_ext = TOT_W'(smp);

    always_comb begin
        unique case (op)
            ACC_LOAD: acc_d = smp_ext;
            default:  acc_d = acc_q + smp_ext;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    // R3
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == ACC_LOAD) |=> (acc_q == TOT_W'($past(smp))));

    // R2
    gather_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == ACC_ADD) |=> (acc_q == $past(acc_q) + TOT_W'($past(smp))));

endmodule

// File: rtl/wavg_shift.sv
module wavg_shift
    import wavg_pkg::*;
#(
    parameter int unsigned SEL_W = DEF_SEL_W,
    parameter int unsigned SMP_W = DEF_SMP_W,
    parameter int unsigned TOT_W = sum_width(DEF_SMP_W, DEF_SEL_W)
) (
    input  logic signed [TOT_W-1:0] sum_in,
    input  logic        [SEL_W-1:0] amt,
    output logic signed [SMP_W-1:0] mean
);

    logic signed [TOT_W-1:0] stage [SEL_W+1];

    assign stage[0] = sum_in;

    for (genvar k = 0; k < SEL_W; k++) begin : g_stage
        localparam int unsigned STEP = 32'd1 << k;
        if (STEP >= TOT_W) begin : g_full
            assign stage[k+1] = amt[k] ? {TOT_W{stage[k][TOT_W-1]}} : stage[k];
        end else begin : g_part
            assign stage[k+1] = amt[k]
                ? {{STEP{stage[k][TOT_W-1]}}, stage[k][TOT_W-1:STEP]}
                : stage[k];
        end
    end

    assign mean = stage[SEL_W][SMP_W-1:0];

endmodule

// File: rtl/wavg_publish.sv
module wavg_publish
    import wavg_pkg::*;
#(
    parameter int unsigned SMP_W = DEF_SMP_W,
    parameter int unsigned TOT_W = sum_width(DEF_SMP_W, DEF_SEL_W)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    publish,
    input  logic signed [TOT_W-1:0] sum_in,
    input  logic signed [SMP_W-1:0] mean_in,
    output logic signed [TOT_W-1:0] total_q,
    output logic signed [SMP_W-1:0] mean_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            total_q <= '0;
            mean_q  <= '0;
        end else if (publish) begin
            total_q <= sum_in;
            mean_q  <= mean_in;
        end
    end

    // R4
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !publish |=> ($stable(total_q) && $stable(mean_q)));

    // R1
    clear_chk: assert property (@(posedge clk)
        !rst_n |=> (total_q == '0 && mean_q == '0));

endmodule

// File: rtl/window_averager.sv
module window_averager
    import wavg_pkg::*;
#(
    parameter int unsigned SMP_W = DEF_SMP_W,
    parameter int unsigned SEL_W = DEF_SEL_W,
    localparam int unsigned TOT_W = SMP_W + (32'd1 << SEL_W)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic signed [SMP_W-1:0] smp_i,
    input  logic        [SEL_W-1:0] shift_sel_i,
    input  logic                    strobe_i,
    output logic signed [TOT_W-1:0] total_o,
    output logic signed [SMP_W-1:0] mean_o
);

    win_ctl_t                ctl;
    logic signed [TOT_W-1:0] acc;
    logic signed [SMP_W-1:0] mean_next;

    assign ctl = decode_strobe(strobe_i);

    wavg_accum #(.SMP_W(SMP_W), .TOT_W(TOT_W)) u_accum (
        .clk   (clk),
        .rst_n (rst_n),
        .op    (ctl.op),
        .smp   (smp_i),
        .acc_q (acc)
    );

    wavg_shift #(.SEL_W(SEL_W), .SMP_W(SMP_W), .TOT_W(TOT_W)) u_shift (
        .sum_in (acc),
        .amt    (shift_sel_i),
        .mean   (mean_next)
    );

    wavg_publish #(.SMP_W(SMP_W), .TOT_W(TOT_W)) u_publish (
        .clk     (clk),
        .rst_n   (rst_n),
        .publish (ctl.publish),
        .sum_in  (acc),
        .mean_in (mean_next),
        .total_q (total_o),
        .mean_q  (mean_o)
    );

    // R2
    publish_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_i |=> (total_o == $past(acc)));

    // R5
    mean_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_i |=> (mean_o == SMP_W'($past(acc) >>> $past(shift_sel_i))));

    // R9
    mean_unshifted_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_i && shift_sel_i == '0) |=> (mean_o == total_o[SMP_W-1:0]));

endmodule

// File: tb/window_averager_tb.sv
module window_averager_tb;

    localparam int CLK_PERIOD = 10;
    localparam int SMP_W = 8;
    localparam int SEL_W = 4;
    localparam int TOT_W = SMP_W + (1 << SEL_W);

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic signed [SMP_W-1:0] smp_i = '0;
    logic        [SEL_W-1:0] shift_sel_i = '0;
    logic                    strobe_i = 1'b0;
    logic signed [TOT_W-1:0] total_o;
    logic signed [SMP_W-1:0] mean_o;

    int    n_checks = 0;
    int    n_errors = 0;
    string cur_req  = "R1";
    bit    finished = 1'b0;

    // behavioural reference state
    longint m_acc  = 0;
    longint m_tot  = 0;
    longint m_mean = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    window_averager #(.SMP_W(SMP_W), .SEL_W(SEL_W)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .smp_i       (smp_i),
        .shift_sel_i (shift_sel_i),
        .strobe_i    (strobe_i),
        .total_o     (total_o),
        .mean_o      (mean_o)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            m_acc = 0; m_tot = 0; m_mean = 0;
        end else if (strobe_i) begin
            m_tot  = m_acc;
            m_mean = m_acc >>> shift_sel_i;
            m_acc  = longint'(smp_i);
        end else begin
            m_acc  = m_acc + longint'(smp_i);
        end
    end

    task automatic check(input string req, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // compare against the model on every cycle, away from the active edge
    always @(negedge clk) begin
        if (!finished) begin
            logic signed [TOT_W-1:0] et;
            logic signed [SMP_W-1:0] em;
            et = TOT_W'(m_tot);
            em = SMP_W'(m_mean);
            check({cur_req, " total"}, longint'(total_o), longint'(et));
            check({cur_req, " mean"},  longint'(mean_o),  longint'(em));
        end
    end

    task automatic feed(input logic st, input int v, input int sel);
        strobe_i    = st;
        smp_i       = SMP_W'(v);
        shift_sel_i = SEL_W'(sel);
        @(negedge clk);
    endtask

    task automatic summary;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        finished = 1'b1;
        summary();
    end

    initial begin
        longint hold_t, hold_m;
        @(negedge clk);
        // R1: reset clears outputs and accumulator
        cur_req = "R1";
        feed(1'b0, 55, 2);
        feed(1'b0, -7, 2);
        check("R1 total after reset", longint'(total_o), 0);
        check("R1 mean after reset", longint'(mean_o), 0);
        rst_n = 1'b1;
        feed(1'b1, 42, 0);
        check("R1 first strobe publishes cleared accumulator", longint'(total_o), 0);

        // R2 R5: window of eight +42, then close with shift 3
        cur_req = "R2";
        for (int i = 0; i < 7; i++) feed(1'b0, 42, 0);
        feed(1'b1, -42, 3);
        check("R2 sum of 8 x 42", longint'(total_o), 336);
        check("R5 mean of 8 x 42", longint'(mean_o), 42);

        // R3 R6: the strobe sample opened an all-negative window
        cur_req = "R3";
        for (int i = 0; i < 7; i++) feed(1'b0, -42, 0);
        feed(1'b1, -3, 3);
        check("R3 strobe sample counted in new window", longint'(total_o), -336);
        check("R6 mean of 8 x -42", longint'(mean_o), -42);

        // R6: one-sample window of -3 published with shift 1
        cur_req = "R6";
        feed(1'b1, -5, 1);
        check("R6 floor of -3/2", longint'(mean_o), -2);
        feed(1'b1, 0, 2);
        check("R6 floor of -5/4", longint'(mean_o), -2);

        // R8: back-to-back strobes, one sample per window
        cur_req = "R8";
        feed(1'b1, 17, 0);
        check("R8 single-sample window zero", longint'(total_o), 0);
        feed(1'b1, -100, 0);
        check("R8 single-sample window 17", longint'(total_o), 17);
        feed(1'b1, 9, 0);
        check("R9 mean equals total low bits", longint'(mean_o), -100);

        // R4: change inputs freely between strobes, outputs hold
        cur_req = "R4";
        hold_t = longint'(total_o);
        hold_m = longint'(mean_o);
        for (int i = 0; i < 6; i++) feed(1'b0, (i * 37) - 90, i * 3);
        check("R4 total held", longint'(total_o), hold_t);
        check("R4 mean held", longint'(mean_o), hold_m);

        // R5 R9: random windows with assorted shift settings
        cur_req = "R5";
        for (int w = 0; w < 40; w++) begin
            int sel = w % 7;
            int len = (1 << sel) + (w % 3);
            for (int i = 0; i < len; i++)
                feed(i == 0, $signed($urandom_range(0, 255)) - 128, sel);
        end
        cur_req = "R9";
        for (int w = 0; w < 10; w++)
            for (int i = 0; i < 3; i++)
                feed(i == 0, $signed($urandom_range(0, 255)) - 128, 0);

        // R7: full-scale windows
        cur_req = "R7";
        feed(1'b1, 127, 0);
        for (int i = 1; i < 1024; i++) feed(1'b0, 127, 10);
        feed(1'b1, -128, 10);
        check("R7 sum of 1024 x 127", longint'(total_o), 130048);
        check("R7 mean of 1024 x 127", longint'(mean_o), 127);
        for (int i = 1; i < 1024; i++) feed(1'b0, -128, 10);
        feed(1'b1, -128, 10);
        check("R7 sum of 1024 x -128", longint'(total_o), -131072);
        for (int i = 1; i < 32768; i++) feed(1'b0, -128, 15);
        feed(1'b1, 0, 15);
        check("R7 sum of 32768 x -128", longint'(total_o), -4194304);
        check("R7 mean of 32768 x -128", longint'(mean_o), -128);

        // R1: reset in mid-window clears the accumulator
        cur_req = "R1";
        feed(1'b0, 99, 0);
        rst_n = 1'b0;
        feed(1'b0, 99, 0);
        check("R1 total cleared mid-window", longint'(total_o), 0);
        rst_n = 1'b1;
        feed(1'b1, 5, 0);
        check("R1 accumulator cleared mid-window", longint'(total_o), 0);
        feed(1'b0, 0, 0);

        finished = 1'b1;
        summary();
    end

endmodule